// File: doc/BRIEF.md
# Serial Receiver with Idle-Line Wakeup Mute

This block receives asynchronous serial characters: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It runs on a clock-enable tick at sixteen times the bit rate. While the enable input is high, the block looks for a falling edge on the line and confirms the start bit half a bit later. It then samples every later bit at its midpoint. A completed character goes into a receive data register and raises a receive-full flag. A read strobe consumes the character.

A mute control lets the host ignore traffic that is not meant for it. While muted, the receiver keeps following frames on the line but delivers nothing and raises no flags. The mute bit clears itself when the line stays high for a full frame time (ten bit times) after a received character. Software can also set or clear the mute bit directly. An idle line seen before any character has arrived since reset never wakes the receiver.

Top module: `uart_mute_rx`

## Requirements
- R1: After a synchronous active-low reset, rx_full, frame_err, overrun and mute all read 0 and data_out reads 0x00.
- R2: While rx_enable is 0, activity on rx_in delivers no character and leaves rx_full at 0.
- R3: A frame on rx_in (start bit 0, eight data bits LSB first, stop bit 1, each 16 ticks long) with mute at 0 and rx_full at 0 loads the data bits into data_out and sets rx_full.
- R4: A low pulse on rx_in shorter than half a bit time is rejected as a false start, and no character is delivered.
- R5: A stop bit sampled as 0 sets frame_err. The data bits are still loaded and rx_full is still set.
- R6: A character that completes while rx_full is 1 sets overrun, and data_out keeps the earlier character.
- R7: A one-cycle rd_strobe clears rx_full, frame_err and overrun.
- R8: A mute_set pulse sets mute and a mute_clr pulse clears it. When both arrive in the same cycle, clearing wins.
- R9: While mute is 1, completed frames change none of data_out, rx_full, frame_err or overrun.
- R10: Once a character has been received since reset, 160 consecutive high ticks on rx_in after the end of a character clear mute by hardware, and the next frame is delivered.
- R11: With no character received since reset, any length of idle line leaves mute at 1.
- R12: A high gap shorter than ten bit times between two muted frames leaves mute at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| rx_enable | input | 1 | Receiver enable level |
| mute_set | input | 1 | Pulse that sets the mute bit |
| mute_clr | input | 1 | Pulse that clears the mute bit |
| rd_strobe | input | 1 | Pulse that consumes the received character |
| data_out | output | 8 | Receive data register |
| rx_full | output | 1 | A character is waiting to be read |
| frame_err | output | 1 | Stop bit of the held character was 0 |
| overrun | output | 1 | A character was lost while rx_full was set |
| mute | output | 1 | Mute bit: 1 means muted, 0 means active |

## Verification
The assertions assume that mute_set, mute_clr and rd_strobe are single-cycle pulses. They also assume that a read strobe never falls in the same cycle as the completion of a character. The tick is assumed steady, so that a bit lasts exactly sixteen ticks. The stimulus holds tick16 high on every clock and changes rx_in only on falling clock edges, in whole sixteen-cycle bit slots. It issues reads only well after a frame has ended and well before the next frame completes.

// File: rtl/uart_mute_pkg.sv
// Package: shared types for the muted serial receiver.
// Assumes: an 8-bit character and one stop bit.
package uart_mute_pkg;
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_WAITH = 3'd4
    } rx_state_t;
endpackage

// File: rtl/uart_line_sync.sv
// Module: brings the asynchronous serial line into the clock domain.
// Assumes: the line idles high, so the stages reset to 1.
module uart_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] stage_q;

    // Shift the line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= {stage_q[STAGES-2:0], line_i};
    end

    assign line_o = stage_q[STAGES-1];
endmodule

// File: rtl/uart_frame_rx.sv
// Module: start-bit search, mid-bit sampling and stop check for one frame.
// Assumes: OSR ticks per bit. It emits a one-cycle done pulse with the data
// and the stop status. After a low stop bit it waits for a high line.
module uart_frame_rx
    import uart_mute_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ferr_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] TOPB = BIT_W'(DATA_W - 1);

    rx_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q;

    // Frame state machine, advanced on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            done_o  <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                unique case (state_q)
                    RX_IDLE: begin
                        cnt_q <= '0;
                        if (!rx_i) state_q <= RX_START;
                    end
                    RX_START: begin
                        if (cnt_q == MID) begin
                            cnt_q   <= '0;
                            bit_q   <= '0;
                            state_q <= rx_i ? RX_IDLE : RX_DATA;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    RX_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {rx_i, sh_q[DATA_W-1:1]};
                            if (bit_q == TOPB) state_q <= RX_STOP;
                            else               bit_q   <= bit_q + 1'b1;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    RX_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            done_o  <= 1'b1;
                            ferr_o  <= !rx_i;
                            state_q <= rx_i ? RX_IDLE : RX_WAITH;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    RX_WAITH: begin
                        if (rx_i) state_q <= RX_IDLE;
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign data_o = sh_q;

    // R2: a disabled receiver sits in its idle state.
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == RX_IDLE));
    // R3: a frame completes only out of the stop-bit state.
    a_r3_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state_q) == RX_STOP);
endmodule

// File: rtl/uart_idle_detect.sv
// Module: counts continuous high ticks after a received character and
// pulses once when a full frame time of idle line has been seen.
// Assumes: done_i pulses at the stop-bit midpoint.
module uart_idle_detect #(
    parameter int IDLE_TICKS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic rx_i,
    input  logic done_i,
    output logic idle_o
);
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(IDLE_TICKS - 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;

    // Arm on a character, count high ticks, fire once on a full idle frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            idle_o  <= 1'b0;
        end else begin
            idle_o <= 1'b0;
            if (done_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (tick_i) begin
                if (!rx_i) cnt_q <= '0;
                else if (armed_q) begin
                    if (cnt_q == LIM) begin
                        idle_o  <= 1'b1;
                        armed_q <= 1'b0;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R11: no idle pulse without a character since the last arming.
    a_r11_idle_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> $past(armed_q));
endmodule

// File: rtl/uart_mute_rx.sv
// Module: top of the receiver. It holds the data register, the status flags
// and the mute bit.
// Assumes: reads never coincide with a completing character, and the
// control inputs are single-cycle pulses.
module uart_mute_rx #(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int FRAME_BITS  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_in,
    input  logic              rx_enable,
    input  logic              mute_set,
    input  logic              mute_clr,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] data_out,
    output logic              rx_full,
    output logic              frame_err,
    output logic              overrun,
    output logic              mute
);
    localparam int IDLE_TICKS = OSR * FRAME_BITS;

    logic              rx_s;
    logic              done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_ferr;
    logic              idle_hit;
    logic              got_char_q;
    logic              wake;

    uart_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .line_i(rx_in), .line_o(rx_s));

    uart_frame_rx #(.OSR(OSR), .DATA_W(DATA_W)) i_frame (
        .clk(clk), .rst_n(rst_n), .en_i(rx_enable), .tick_i(tick16),
        .rx_i(rx_s), .done_o(done), .data_o(fr_data), .ferr_o(fr_ferr));

    uart_idle_detect #(.IDLE_TICKS(IDLE_TICKS)) i_idle (
        .clk(clk), .rst_n(rst_n), .en_i(rx_enable), .tick_i(tick16),
        .rx_i(rx_s), .done_i(done), .idle_o(idle_hit));

    assign wake = idle_hit && got_char_q;

    // Remember whether any character has arrived since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    got_char_q <= 1'b0;
        else if (done) got_char_q <= 1'b1;
    end

    // Mute bit: a clear (software or wakeup) has priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)                mute <= 1'b0;
        else if (mute_clr || wake) mute <= 1'b0;
        else if (mute_set)         mute <= 1'b1;
    end

    // Data register and flags: deliver unmuted characters, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out  <= '0;
            rx_full   <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else if (done && !mute) begin
            if (rx_full) overrun <= 1'b1;
            else begin
                data_out  <= fr_data;
                rx_full   <= 1'b1;
                frame_err <= fr_ferr;
            end
        end else if (rd_strobe) begin
            rx_full   <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end
    end

    // R9: the full flag never rises while muted.
    a_r9_no_delivery_muted: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> !$past(mute));
    // R6: overrun needs a held character, and the data stays untouched.
    a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(rx_full) && $stable(data_out)));
    // R10: mute falls only through software or after a character.
    a_r10_mute_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> ($past(mute_clr) || $past(got_char_q)));
    // R7: a read with no completing character empties the register.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !done) |=> !rx_full && !overrun);
endmodule

// File: tb/test_uart_mute_rx.sv
module test_uart_mute_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rx_in = 1'b1;
    logic       rx_enable = 1'b0;
    logic       mute_set = 1'b0;
    logic       mute_clr = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] data_out;
    logic       rx_full, frame_err, overrun, mute;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    uart_mute_rx i_uart_mute_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .rx_enable(rx_enable), .mute_set(mute_set), .mute_clr(mute_clr),
        .rd_strobe(rd_strobe), .data_out(data_out), .rx_full(rx_full),
        .frame_err(frame_err), .overrun(overrun), .mute(mute));

    // {stop bit, data byte}
    localparam logic [8:0] VEC [5] = '{9'h1A5, 9'h100, 9'h1FF, 9'h03C, 9'h181};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_bits(input int n);
        rx_in = 1'b1;
        repeat (n * 16) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic stop);
        rx_in = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            repeat (16) @(negedge clk);
        end
        rx_in = stop;
        repeat (16) @(negedge clk);
        rx_in = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_read();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        rx_enable = 1'b1;
        do_reset();
        // R1 reset state
        check("R1 rx_full", rx_full, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 overrun", overrun, 0);
        check("R1 mute", mute, 0);
        check("R1 data_out", data_out, 0);
        idle_bits(2);

        // R3/R5/R7 vector table
        for (int k = 0; k < 5; k++) begin
            send(VEC[k][7:0], VEC[k][8]);
            check("R3 rx_full set", rx_full, 1);
            check("R3 data_out", data_out, VEC[k][7:0]);
            check("R5 frame_err", frame_err, !VEC[k][8]);
            pulse_read();
            check("R7 rx_full cleared", rx_full, 0);
            check("R7 frame_err cleared", frame_err, 0);
            idle_bits(2);
        end

        // R4 short low glitch
        rx_in = 1'b0; repeat (4) @(negedge clk); rx_in = 1'b1;
        idle_bits(12);
        check("R4 glitch rejected", rx_full, 0);

        // R6 overrun
        send(8'h12, 1'b1);
        idle_bits(1);
        send(8'h34, 1'b1);
        check("R6 overrun set", overrun, 1);
        check("R6 old data kept", data_out, 8'h12);
        pulse_read();
        check("R7 overrun cleared", overrun, 0);
        idle_bits(2);

        // R2 disabled receiver
        rx_enable = 1'b0;
        send(8'h5A, 1'b1);
        check("R2 disabled no data", rx_full, 0);
        rx_enable = 1'b1;
        idle_bits(2);

        // R8 software mute control
        mute_set = 1'b1; @(negedge clk); mute_set = 1'b0; @(negedge clk);
        check("R8 set", mute, 1);
        mute_set = 1'b1; mute_clr = 1'b1; @(negedge clk);
        mute_set = 1'b0; mute_clr = 1'b0; @(negedge clk);
        check("R8 clear wins", mute, 0);

        // R11 no wakeup before any character
        do_reset();
        mute_set = 1'b1; @(negedge clk); mute_set = 1'b0;
        idle_bits(25);
        check("R11 still muted", mute, 1);

        // R9 muted frames are dropped
        send(8'h55, 1'b1);
        check("R9 no rx_full", rx_full, 0);
        check("R9 data unchanged", data_out, 0);
        idle_bits(5);
        send(8'h66, 1'b0);
        check("R9 no frame_err", frame_err, 0);
        check("R12 short gap keeps mute", mute, 1);
        idle_bits(12);
        check("R10 idle wakeup", mute, 0);
        send(8'h77, 1'b1);
        check("R10 delivered after wake", rx_full, 1);
        check("R10 data after wake", data_out, 8'h77);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule